// File: doc/BRIEF.md
# Single-Wire Register Bus Host

This block is the host end of a one-wire, open-drain serial link used to read and write byte-wide or word-wide registers in a target device. The host never drives the wire high. It either pulls the wire low or lets go, and an external pullup restores the idle high level. Each bit is a return-to-one symbol: a low pulse followed by released time, with the wire high again before the bit cycle closes. The width of the low pulse carries the bit value.

A transaction begins with a command byte, sent LSB first: seven address bits, then a direction flag. For a write, the data bits follow the command on the same timing. For a read, the host releases the wire after the direction bit and measures each low pulse the target returns. The data phase is 8 or 16 bits long, chosen per transaction. The bit cycle, the two pulse widths and the response timeout are parameters counted in clock cycles. The user raises `start` with the address, write data, direction and width. One cycle of `done` marks the end of the transaction, with `timeout_err` set when the target stayed silent.

Top module: `hdq_host`

## Requirements
- R1: During and after reset, with no start, `line_drive_low`, `busy`, `done` and `timeout_err` are 0 and `rd_data` is 0.
- R2: The command byte goes out LSB first: `addr[0]` through `addr[6]`, then the direction flag (1 = write, 0 = read). Each bit cycle starts with a falling edge, and consecutive host falling edges within a transaction are exactly `BIT_CYC` clocks apart.
- R3: A host bit of value 1 drives the wire low for exactly `ONE_LOW` clocks, and a bit of value 0 for exactly `ZERO_LOW` clocks. The wire is released for the rest of the cycle.
- R4: On a write, the data bits follow the command LSB first. There are 8 of them (`wr_data[7:0]`) when `wide`=0 and 16 when `wide`=1.
- R5: On a read, the host decodes each target low pulse. A pulse shorter than (`ONE_LOW`+`ZERO_LOW`)/2 clocks is a 1, and any other pulse is a 0. Bits arrive LSB first. `rd_data` receives all 16 bits when `wide`=1, or the 8 bits zero-extended when `wide`=0.
- R6: The host accepts a first response falling edge that arrives as soon as the direction bit's own cycle has ended, with no extra gap.
- R7: If no falling edge arrives within `RESP_TMO` clocks while a response bit is awaited, `done` and `timeout_err` pulse together and `rd_data` keeps its old value. For a silent first bit, this happens at the (8·`BIT_CYC`+`RESP_TMO`)-th clock edge after the edge that accepts `start`.
- R8: `done` is high for exactly one cycle. On a write, it rises at the N·`BIT_CYC`-th clock edge after the accepting edge, where N is 16 or 24.
- R9: A `start` raised while `busy` is high is ignored: the running transaction goes on unchanged, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| write | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 16-bit data phase, 0 = 8-bit |
| addr | input | 7 | Register address |
| wr_data | input | 16 | Write data (low byte used in 8-bit mode) |
| rd_data | output | 16 | Last successfully read data |
| done | output | 1 | One-cycle end-of-transaction pulse |
| timeout_err | output | 1 | Pulses with done when the response timed out |
| busy | output | 1 | Transaction in progress |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| line_in | input | 1 | Sampled wire level |

## Verification
The bench counts clock edges from the edge that accepts `start`. On a write, `done` must be seen at edge N·`BIT_CYC`+1 of its own count, and for a silent target at 8·`BIT_CYC`+`RESP_TMO`+1. These exact counts are compared, not windows. Read data depends on the target's reply timing, so it is checked only when `done` rises. Each host pulse width and each fall-to-fall interval is measured cycle by cycle as the wire changes. All outputs are sampled at the falling clock edge, half a cycle after the registers update.

// File: rtl/hdq_host.sv
module hdq_host #(
  parameter int BIT_CYC  = 40000,
  parameter int ONE_LOW  = 8000,
  parameter int ZERO_LOW = 28000,
  parameter int RESP_TMO = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic        wide,
  input  logic [6:0]  addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        done,
  output logic        timeout_err,
  output logic        busy,
  output logic        line_drive_low,
  input  logic        line_in
);

  localparam int DEC_THR = (ONE_LOW + ZERO_LOW) / 2;
  localparam int MAXC    = (RESP_TMO > BIT_CYC) ? RESP_TMO : BIT_CYC;
  localparam int CW      = $clog2(MAXC + 2);
  localparam logic [CW-1:0] BIT_END = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] TMO_END = CW'(RESP_TMO - 1);
  localparam logic [CW-1:0] ONE_C   = CW'(ONE_LOW);
  localparam logic [CW-1:0] ZERO_C  = CW'(ZERO_LOW);
  localparam logic [CW-1:0] THR_C   = CW'(DEC_THR);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RXW, S_RXL} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [23:0]    sh;
  logic [4:0]     nleft;
  logic [4:0]     rleft;
  logic [15:0]    rsh;
  logic           is_wr, is_wide;
  logic           s1, s2, s2_d;
  logic           rx_bit;
  logic [15:0]    rx_next;

  assign busy           = (st != S_IDLE);
  assign line_drive_low = (st == S_TX) && (cnt < (sh[0] ? ONE_C : ZERO_C));
  assign rx_bit         = (cnt < THR_C);
  assign rx_next        = {rx_bit, rsh[15:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; nleft <= '0; rleft <= '0;
      rsh <= '0; is_wr <= 1'b0; is_wide <= 1'b0; rd_data <= '0;
      done <= 1'b0; timeout_err <= 1'b0;
      s1 <= 1'b1; s2 <= 1'b1; s2_d <= 1'b1;
    end else begin
      done <= 1'b0;
      timeout_err <= 1'b0;
      s1 <= line_in; s2 <= s1; s2_d <= s2;
      case (st)
        S_IDLE: if (start) begin
          sh      <= {wr_data, write, addr};
          is_wr   <= write;
          is_wide <= wide;
          nleft   <= write ? (wide ? 5'd24 : 5'd16) : 5'd8;
          cnt     <= '0;
          st      <= S_TX;
        end
        S_TX: if (cnt == BIT_END) begin
          cnt   <= '0;
          sh    <= sh >> 1;
          nleft <= nleft - 5'd1;
          if (nleft == 5'd1) begin
            if (is_wr) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              rleft <= is_wide ? 5'd16 : 5'd8;
              rsh   <= '0;
              st    <= S_RXW;
            end
          end
        end else cnt <= cnt + 1'b1;
        S_RXW: if (s2_d && !s2) begin
          cnt <= CW'(1);
          st  <= S_RXL;
        end else if (cnt == TMO_END) begin
          done <= 1'b1; timeout_err <= 1'b1; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_RXL: if (s2) begin
          rsh   <= rx_next;
          rleft <= rleft - 5'd1;
          cnt   <= '0;
          if (rleft == 5'd1) begin
            rd_data <= is_wide ? rx_next : {8'h00, rx_next[15:8]};
            done    <= 1'b1;
            st      <= S_IDLE;
          end else st <= S_RXW;
        end else if (cnt == TMO_END) begin
          done <= 1'b1; timeout_err <= 1'b1; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_drive_low);
  assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || timeout_err) |=> $stable(rd_data));
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/tb_hdq_host.sv
`timescale 1ns/1ps
module tb_hdq_host;
  localparam int BC = 40, T1 = 8, T0 = 24, TMO = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, write = 0, wide = 0;
  logic [6:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic done, timeout_err, busy, line_drive_low, line_in;
  logic tgt_low = 1'b0;

  assign line_in = !(line_drive_low || tgt_low);
  always #2.5 clk = ~clk;

  hdq_host #(.BIT_CYC(BC), .ONE_LOW(T1), .ZERO_LOW(T0), .RESP_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .wide(wide),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .timeout_err(timeout_err), .busy(busy), .line_drive_low(line_drive_low),
    .line_in(line_in));

  int total = 0, bad = 0;
  int cyc = 0, lowlen = 0, capn = 0, hfall = 0, badper = 0, badpulse = 0;
  logic hfall_ok = 1'b0, by_tgt = 1'b0, mon_prev = 1'b1;
  logic caparr [4096];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mon_prev <= line_in;
    if (mon_prev === 1'b1 && line_in === 1'b0 && !tgt_low) begin
      if (hfall_ok && (cyc - hfall) != BC && (cyc - hfall) < 2*BC) badper <= badper + 1;
      hfall <= cyc;
      hfall_ok <= 1'b1;
    end
    if (line_in === 1'b0) begin
      lowlen <= lowlen + 1;
      if (tgt_low) by_tgt <= 1'b1;
    end else if (lowlen != 0) begin
      if (!by_tgt) begin
        if (lowlen == T1) caparr[capn % 4096] <= 1'b1;
        else if (lowlen == T0) caparr[capn % 4096] <= 1'b0;
        else badpulse <= badpulse + 1;
        capn <= capn + 1;
      end
      lowlen <= 0;
      by_tgt <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_frame(input logic wr, input logic [6:0] a, input logic [15:0] d);
    return {d, wr, a};
  endfunction

  function automatic logic [15:0] exp_rd(input logic w, input logic [15:0] d);
    return w ? d : {8'h00, d[7:0]};
  endfunction

  task automatic respond(input int base, input logic [15:0] d, input int nb, input int gap);
    while (capn - base < 8) @(negedge clk);
    while (cyc < hfall + BC + gap) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      int len;
      len = d[i] ? T1 : T0;
      tgt_low = 1'b1;
      repeat (len) @(negedge clk);
      tgt_low = 1'b0;
      repeat (BC - len) @(negedge clk);
    end
  endtask

  task automatic txn(input logic wr, input logic w, input logic [6:0] a, input logic [15:0] d,
                     input int gap, input bit silent, input bit poke);
    int base, k, bp0, bw0, n;
    logic [15:0] prev;
    logic [23:0] fr;
    base = capn; bp0 = badpulse; bw0 = badper; prev = rd_data;
    n = wr ? (w ? 24 : 16) : 8;
    fr = exp_frame(wr, a, d);
    @(negedge clk);
    write = wr; wide = w; addr = a; wr_data = d; start = 1'b1;
    if (!wr && !silent) fork respond(base, d, w ? 16 : 8, gap); join_none
    k = 0;
    while (k < 5000) begin
      @(posedge clk); k++;
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 45) begin
        start = 1'b1; addr = a ^ 7'h55; write = ~wr; wr_data = ~d;
      end
      if (done) break;
    end
    chk(done === 1'b1, "R8 done seen", k, 0);
    chk(timeout_err === silent, "R7 error flag", timeout_err, silent);
    if (wr) chk(k == n*BC + 1, "R8 write latency", k, n*BC + 1);
    if (silent) chk(k == 8*BC + TMO + 1, "R7 timeout latency", k, 8*BC + TMO + 1);
    chk(capn - base == n, "R2 host bit count", capn - base, n);
    for (int i = 0; i < n; i++) begin
      if (caparr[(base + i) % 4096] !== fr[i]) begin
        chk(0, (i < 8) ? "R2 command bit" : "R4 data bit", {caparr[(base + i) % 4096], 8'(i)}, {fr[i], 8'(i)});
        break;
      end
    end
    chk(badpulse == bp0, "R3 pulse widths", badpulse - bp0, 0);
    chk(badper == bw0, "R2 bit period", badper - bw0, 0);
    if (!wr && !silent) chk(rd_data == exp_rd(w, d), (gap == 0) ? "R6 no-gap read" : "R5 read data", rd_data, exp_rd(w, d));
    if (silent) chk(rd_data == prev, "R7 data kept", rd_data, prev);
    @(negedge clk);
    chk(done === 1'b0, "R8 one-cycle done", done, 0);
    repeat (BC + 5) @(negedge clk);
    chk(!busy && capn - base == n, "R9 no extra transaction", capn - base, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d5e);
    repeat (4) @(negedge clk);
    chk(line_drive_low === 0 && busy === 0 && done === 0 && timeout_err === 0 && rd_data === 0,
        "R1 reset state", {line_drive_low, busy, done, timeout_err, rd_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_drive_low === 0 && busy === 0, "R1 idle after reset", {line_drive_low, busy}, 0);

    txn(1, 0, 7'h7F, 16'h00A5, 0, 0, 0);
    txn(1, 1, 7'h01, 16'hF00F, 0, 0, 0);
    txn(0, 1, 7'h2A, 16'hBEEF, 0, 0, 0);
    txn(0, 0, 7'h00, 16'hFF80, 0, 0, 0);
    txn(0, 1, 7'h33, 16'h0000, 5, 1, 0);
    txn(1, 1, 7'h12, 16'h3C5A, 0, 0, 1);
    txn(0, 0, 7'h44, 16'h00FF, 20, 0, 1);
    for (int t = 0; t < 22; t++) begin
      logic wr, w;
      wr = 1'($urandom);
      w = 1'($urandom);
      txn(wr, w, 7'($urandom), 16'($urandom), int'($urandom % 25), 0, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule